// File: doc/BRIEF.md
# SPI Master with Programmable Input Capture Delay

This block is an SPI bus master for a single slave. Software fills a transmit queue through a push port. While the run/stop control bit is cleared, the master sends each queued word as one frame of `DATA_W` bits. The first bit on the wire is the most significant bit. Select stays low for the whole frame. SCK idles low, data is launched on falling SCK edges and read back on rising SCK edges. Received words go into a receive queue, which is read through a pop port. A 16-bit frame counter lets software track progress through its queue.

Long traces or slow slaves can return data late. For that case, an alternative timing mode moves the capture of the serial input 0, 1 or 2 system clocks past the rising SCK edge. The receive queue can also be turned off. The receiver then works as a single holding register behind the shifter, and a late read is reported by a sticky overrun flag. Both queues can be emptied by writing self-clearing command bits.

Top module: `spi_dly_master`

## Requirements
- R1: After reset the control register reads 0x0001 (stopped), the frame counter and status read 0, `cs_n` is 1, `sck` is 0 and `rx_valid` is 0.
- R2: A frame drives `cs_n` low throughout and produces `DATA_W` rising SCK edges with a period of `CLK_DIV` system clocks. Data leaves on `sout` most significant bit first and changes only on a falling SCK edge or at frame start.
- R3: With control bit 1 (late-capture mode) at 0, `sin` is captured on the system clock edge where SCK rises, whatever the delay field holds.
- R4: With control bit 1 at 1, control bits [6:5] = 0, 1 or 2 delay the capture of `sin` by that many system clocks after each rising SCK edge.
- R5: Delay code 3 is invalid and captures exactly as code 0.
- R6: Control bit 0 (stop) blocks new frames. A frame starts only while stop is 0 and the transmit queue holds data. Setting stop during a frame lets that frame complete and starts no further frame.
- R7: The frame counter (address 1) increments by one for every completed frame.
- R8: A write to the frame counter takes effect only while stop is 1. While stop is 0 it is ignored.
- R9: Writing 1 to control bit 3 empties the transmit queue. The bit reads back as 0.
- R10: Writing 1 to control bit 4 empties the receive queue. The bit reads back as 0.
- R11: With control bit 2 at 1, the receiver holds one word. A frame that completes while that word is unread replaces it and sets the sticky overrun flag (status bit 0). Writing 1 to status bit 0 clears the flag.
- R12: Status (address 2) reports overrun in bit 0, frame active in bit 1, transmit queue level in bits [7:4] and receive queue level in bits [11:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 frame counter, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | DATA_W | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the word shown on `rx_data` |
| rx_data | output | DATA_W | Oldest received word |
| rx_valid | output | 1 | A received word is available |
| sck | output | 1 | Serial clock, idles low |
| sout | output | 1 | Serial data to slave |
| sin | input | 1 | Serial data from slave |
| cs_n | output | 1 | Active-low slave select |

## Verification
A capture point that is off by one clock would show up at once in the first frame of each timing mode. It would appear as a received word that comes from the wrong one of three slave patterns, because those patterns change in the clocks around each rising SCK edge. Queue-level and counter errors appear in the status and counter registers in the cycle after the frame ends. A stop bit that is honoured too early or too late shows as a transmit level different from the expected one after a stopped burst.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

    // control register image; bit 0 is stop
    typedef struct packed {
        logic [1:0] dly_code;
        logic       flush_rx;
        logic       flush_tx;
        logic       rx_single;
        logic       late_cap;
        logic       stop;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    function automatic logic [1:0] capture_delay(input logic late, input logic [1:0] code);
        if (!late || code == 2'b11) return 2'd0;
        return code;
    endfunction

endpackage

// File: rtl/spi_dly_fifo.sv
module spi_dly_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rp];

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R9 R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

    // R12
    full_push_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> count == $past(count));

endmodule

// File: rtl/spi_dly_engine.sv
module spi_dly_engine
    import spi_dly_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [1:0]        cap_dly,
    input  logic              sin,
    output logic              tx_take,
    output logic              sck,
    output logic              sout,
    output logic              cs_n,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int EW   = $clog2(2 * DATA_W + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DATA_W - 1);

    eng_state_e        state;
    logic [DW-1:0]     div;
    logic [EW-1:0]     edges;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic [1:0]        rise_q;
    logic              tick, rise_now, cap;

    assign tick     = (div == DW'(HALF - 1));
    assign rise_now = (state == ENG_RUN) && tick && !sck;
    assign tx_take  = (state == ENG_IDLE) && start_ok;
    assign sout     = tx_sh[DATA_W-1];
    assign rx_word  = rx_sh;

    always_comb begin
        case (cap_dly)
            2'd1:    cap = rise_q[0];
            2'd2:    cap = rise_q[1];
            default: cap = rise_now;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            sck    <= 1'b0;
            cs_n   <= 1'b1;
            div    <= '0;
            edges  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            rise_q <= '0;
            done   <= 1'b0;
        end else begin
            done   <= 1'b0;
            rise_q <= {rise_q[0], rise_now};
            if (cap) rx_sh <= {rx_sh[DATA_W-2:0], sin};
            case (state)
                ENG_IDLE: if (start_ok) begin
                    tx_sh <= tx_word;
                    cs_n  <= 1'b0;
                    div   <= '0;
                    edges <= '0;
                    state <= ENG_RUN;
                end
                ENG_RUN: begin
                    if (tick) begin
                        div   <= '0;
                        sck   <= ~sck;
                        edges <= edges + 1'b1;
                        if (sck) begin
                            if (edges == LAST_EDGE) begin
                                cs_n  <= 1'b1;
                                done  <= 1'b1;
                                state <= ENG_IDLE;
                            end else begin
                                tx_sh <= tx_sh << 1;
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R2
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R2
    sout_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$fell(sck) && !$fell(cs_n)) |-> $stable(sout));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_IDLE && !start_ok) |=> cs_n);

endmodule

// File: rtl/spi_dly_master.sv
module spi_dly_master
    import spi_dly_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 4,
    parameter int CLK_DIV = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sck,
    output logic              sout,
    input  logic              sin,
    output logic              cs_n
);
    localparam int CW = $clog2(DEPTH + 1);

    ctrl_t             ctrl_q, ctrl_w;
    logic [15:0]       frame_cnt;
    logic              ovr;
    logic [DATA_W-1:0] hold_word;
    logic              hold_full;

    assign ctrl_w = ctrl_t'(reg_wdata[6:0]);

    logic wr_ctrl, wr_cnt, wr_stat, flush_tx, flush_rx;
    assign wr_ctrl  = reg_wr && reg_addr == ADDR_CTRL;
    assign wr_cnt   = reg_wr && reg_addr == ADDR_CNT && ctrl_q.stop;
    assign wr_stat  = reg_wr && reg_addr == ADDR_STAT;
    assign flush_tx = wr_ctrl && ctrl_w.flush_tx;
    assign flush_rx = wr_ctrl && ctrl_w.flush_rx;

    logic [DATA_W-1:0] txq_out, rxq_out, eng_rx;
    logic [CW-1:0]     txq_cnt, rxq_cnt;
    logic              txq_empty, rxq_full, rxq_empty;
    logic              eng_take, eng_done;

    spi_dly_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(flush_tx),
        .push(tx_push), .din(tx_data), .pop(eng_take),
        .dout(txq_out), .count(txq_cnt), .full(tx_full), .empty(txq_empty));

    logic rxq_push, rxq_pop;
    assign rxq_push = eng_done && !ctrl_q.rx_single;
    assign rxq_pop  = rx_pop && !ctrl_q.rx_single;

    spi_dly_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(flush_rx),
        .push(rxq_push), .din(eng_rx), .pop(rxq_pop),
        .dout(rxq_out), .count(rxq_cnt), .full(rxq_full), .empty(rxq_empty));

    spi_dly_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst(rst),
        .start_ok(!ctrl_q.stop && !txq_empty),
        .tx_word(txq_out),
        .cap_dly(capture_delay(ctrl_q.late_cap, ctrl_q.dly_code)),
        .sin(sin), .tx_take(eng_take),
        .sck(sck), .sout(sout), .cs_n(cs_n),
        .done(eng_done), .rx_word(eng_rx));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '{stop: 1'b1, default: '0};
            frame_cnt <= '0;
            ovr       <= 1'b0;
            hold_word <= '0;
            hold_full <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q          <= ctrl_w;
                ctrl_q.flush_tx <= 1'b0;
                ctrl_q.flush_rx <= 1'b0;
            end
            if (wr_cnt) frame_cnt <= reg_wdata;
            else if (eng_done) frame_cnt <= frame_cnt + 1'b1;

            if (eng_done && ctrl_q.rx_single) begin
                hold_word <= eng_rx;
                hold_full <= 1'b1;
                if (hold_full && !rx_pop) ovr <= 1'b1;
            end else if ((rx_pop && ctrl_q.rx_single) || flush_rx) begin
                hold_full <= 1'b0;
            end
            if (wr_stat && reg_wdata[0]) ovr <= 1'b0;
        end
    end

    assign rx_valid = ctrl_q.rx_single ? hold_full : !rxq_empty;
    assign rx_data  = ctrl_q.rx_single ? hold_word : rxq_out;

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {9'd0, ctrl_q};
            ADDR_CNT:  reg_rdata = frame_cnt;
            ADDR_STAT: reg_rdata = {4'd0, 4'(rxq_cnt), 4'(txq_cnt), 2'd0, !cs_n, ovr};
            default:   reg_rdata = '0;
        endcase
    end

    // R9 R10
    flush_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.flush_tx && !ctrl_q.flush_rx);

    // R8
    cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CNT && !ctrl_q.stop && !eng_done)
        |=> frame_cnt == $past(frame_cnt));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !wr_cnt) |=> frame_cnt == $past(frame_cnt) + 16'd1);

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(wr_stat && reg_wdata[0])) |=> ovr);

    // R11
    rxq_no_drop_warn_chk: assert property (@(posedge clk) disable iff (rst)
        (rxq_full && rxq_push && !rxq_pop) |=> rxq_full);

endmodule

// File: tb/spi_dly_master_test.sv
module spi_dly_master_test;
    localparam int DW   = 8;
    localparam int DIV  = 6;
    localparam int DEP  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          tx_push = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_full;
    logic          rx_pop = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          sck, sout, cs_n;
    logic          sin = 1'b0;

    spi_dly_master #(.DATA_W(DW), .DEPTH(DEP), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
        .sck(sck), .sout(sout), .sin(sin), .cs_n(cs_n));

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // slave model: three patterns, switched in the clocks around each rising edge
    logic [DW-1:0] slv0 = 8'hA5;
    logic [DW-1:0] slv1 = 8'h3C;
    logic [DW-1:0] slv2 = 8'hF0;
    logic [DW-1:0] mosi = '0, last_mosi = '0;
    int rises = 0, last_rises = 0, ph = 9, cyc = 0, last_rise_cyc = 0, period = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (cs_n) begin
            if (!prev_cs) begin
                last_mosi  = mosi;
                last_rises = rises;
            end
            rises = 0;
            ph    = 9;
        end else if (sck && !prev_sck) begin
            rises++;
            ph   = 0;
            mosi = {mosi[DW-2:0], sout};
            if (rises > 1) period = cyc - last_rise_cyc;
            last_rise_cyc = cyc;
        end else if (ph < 9) begin
            ph++;
        end
        if (!cs_n && ph == 0)      sin = slv1[DW-rises];
        else if (!cs_n && ph == 1) sin = slv2[DW-rises];
        else if (rises < DW)       sin = slv0[DW-1-rises];
        else                       sin = 1'b0;
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input logic [DW-1:0] w);
        @(negedge clk);
        tx_push = 1'b1; tx_data = w;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_idle(input string req, input int cycles);
        int n = 0;
        repeat (3) @(negedge clk);
        while (!cs_n && n < cycles) begin
            @(negedge clk);
            n++;
        end
        if (n >= cycles) chk(req, 16'hDEAD, 16'h0);
    endtask

    task automatic wait_rx(input string req);
        int n = 0;
        while (!rx_valid && n < 600) begin
            @(negedge clk);
            n++;
        end
        chk(req, {15'd0, rx_valid}, 16'd1);
    endtask

    // {tx[18:11], late[10], code[9:8], expected rx[7:0]}
    localparam logic [18:0] VEC [6] = '{
        {8'hC3, 1'b0, 2'd0, 8'hA5},
        {8'h5E, 1'b0, 2'd2, 8'hA5},
        {8'h81, 1'b1, 2'd0, 8'hA5},
        {8'h7E, 1'b1, 2'd1, 8'h3C},
        {8'h29, 1'b1, 2'd2, 8'hF0},
        {8'hB4, 1'b1, 2'd3, 8'hA5}
    };

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R6 actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 16'h0001);
        rd(2'd1, d); chk("R1 count", d, 16'h0000);
        rd(2'd2, d); chk("R1 status", d, 16'h0000);
        chk("R1 pins cs_n/sck", {14'd0, cs_n, sck}, 16'h0002);
        chk("R1 rx_valid", {15'd0, rx_valid}, 16'd0);

        // vector table: timing modes and capture points
        for (int i = 0; i < 6; i++) begin
            logic [15:0] cw;
            cw = {9'd0, VEC[i][9:8], 2'b00, 1'b0, VEC[i][10], 1'b0};
            wr(2'd0, cw | 16'h0001);
            push(VEC[i][18:11]);
            wr(2'd0, cw);
            wait_rx("R6 frame start");
            wait_idle("R2 frame end", 400);
            chk($sformatf("R3/R4/R5 rx row %0d", i), {8'd0, rx_data}, {8'd0, VEC[i][7:0]});
            chk($sformatf("R2 mosi row %0d", i), {8'd0, last_mosi}, {8'd0, VEC[i][18:11]});
            pop();
            wr(2'd0, cw | 16'h0001);
        end
        chk("R2 rising edges per frame", 16'(last_rises), 16'(DW));
        chk("R2 sck period", 16'(period), 16'(DIV));
        chk("R12 rx empty after pops", {15'd0, rx_valid}, 16'd0);

        // R7 frame counter
        rd(2'd1, d); chk("R7 count after 6", d, 16'd6);

        // R8 counter write while running is ignored
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0055);
        rd(2'd1, d); chk("R8 write ignored when running", d, 16'd6);
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R8 write taken when stopped", d, 16'd0);

        // R6 stop mid-frame finishes current frame only
        push(8'h11);
        push(8'h22);
        wr(2'd0, 16'h0000);
        while (cs_n) @(negedge clk);
        wr(2'd0, 16'h0001);
        repeat (200) @(negedge clk);
        rd(2'd2, d); chk("R6 stop mid-frame status", d, 16'h0110);
        rd(2'd1, d); chk("R7 count after stopped burst", d, 16'd1);

        // R9 flush transmit
        wr(2'd0, 16'h0009);
        rd(2'd2, d); chk("R9 tx flushed", d, 16'h0100);
        rd(2'd0, d); chk("R9 flush bit reads 0", d, 16'h0001);

        // R10 flush receive
        wr(2'd0, 16'h0011);
        rd(2'd2, d); chk("R10 rx flushed", d, 16'h0000);
        rd(2'd0, d); chk("R10 flush bit reads 0", d, 16'h0001);
        chk("R10 rx_valid", {15'd0, rx_valid}, 16'd0);

        // R11 single-register receive with overrun
        wr(2'd0, 16'h0005);
        push(8'h33);
        wr(2'd0, 16'h0004);
        wait_rx("R11 first word");
        wait_idle("R11 end1", 400);
        wr(2'd0, 16'h0005);
        rd(2'd2, d); chk("R11 no overrun yet", d, 16'h0000);
        chk("R11 first data", {8'd0, rx_data}, 16'h00A5);
        slv0 = 8'h96;
        push(8'h44);
        wr(2'd0, 16'h0004);
        repeat (5) @(negedge clk);
        wait_idle("R11 end2", 400);
        wr(2'd0, 16'h0005);
        chk("R11 overwrite data", {8'd0, rx_data}, 16'h0096);
        rd(2'd2, d); chk("R11 overrun set", d, 16'h0001);
        wr(2'd2, 16'h0001);
        rd(2'd2, d); chk("R11 overrun cleared", d, 16'h0000);
        pop();
        chk("R11 emptied by pop", {15'd0, rx_valid}, 16'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule